// File: doc/BRIEF.md
# Multiplexed GPIO Port Data Register

This block is an eight-pin general-purpose I/O port that sits on a peripheral register bus. Each pin has a 2-bit mode field held in a 16-bit control register. The mode sets what the pin does: it can hand the pin to an alternate function, drive it as an output, or sample it as an input with or without a pull-up. An 8-bit data register holds one bit per pin. A CPU write always updates that register. Only pins in output mode send the stored bit to the pad.

On a read of the data address, each bit is chosen by that pin's own mode. Pins in output or alternate mode return the stored register bit. Pins in either input mode return the pad level after a two-flop synchronizer. The port drives an output enable and a pull-up enable for each pin. In alternate mode both enables stay low, and the alternate-function logic owns the pad.

There are two resets. Power-on reset clears both registers. Warm reset, used for manual reset, sleep and standby, clears only the synchronizer and leaves both registers as they were. The register bus takes a write in a single cycle and never stalls. Read data is combinational from the selected address, so there is no valid/ready handshake and no back-pressure to manage.

Top module: `gpio_mux_port`

## Requirements
- R1: While por_n is low, and afterwards until a write, both registers read 0: rd_data is 0 at both addresses, and pin_oe, pin_pu and pin_out are all 0.
- R2: A write with addr_sel=0 stores wr_data[7:0] in the data register. A pin in output mode (code 01) reads back its stored bit.
- R3: A pin in alternate mode (code 00) reads back its stored data bit, and its pin_oe and pin_pu are 0.
- R4: A pin in input mode (code 10 or 11) reads back pin_in through two flops. A change of pin_in appears in rd_data after the second rising edge, and not after the first.
- R5: pin_oe[n] is 1 exactly when pin n has code 01. In that case pin_out[n] equals its stored data bit. Otherwise pin_out[n] is 0.
- R6: pin_pu[n] is 1 exactly when pin n has code 10.
- R7: A data write made while a pin is not in output mode leaves pin_out unchanged. The written bit is still stored, and it drives the pin once the mode changes to 01.
- R8: Holding warm_rst_n low leaves both the data register and the control register unchanged.
- R9: A write with addr_sel=1 stores wr_data[15:0] as the control register, which reads back at addr_sel=1. Pin n's mode is bits [2n+1:2n].
- R10: Each pin applies its own mode, so pins in different modes work side by side in the same read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears both registers |
| warm_rst_n | input | 1 | Asynchronous warm reset, active low; clears only the synchronizer |
| wr_en | input | 1 | Single-cycle write strobe |
| addr_sel | input | 1 | Register select: 0 is the data register, 1 is the control register |
| wr_data | input | 16 | Write data; the data register takes bits [7:0] |
| rd_data | output | 16 | Combinational read data for the selected register |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values, gated by the output enable |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
A corrupted mode field shows up at the ports in the same cycle. It changes pin_oe and pin_pu, and it changes which source the data read returns. Because of this, every vector checks both enables and both read addresses together. A data register bit that is wrong but hidden behind a non-output mode only becomes visible when the pin moves to output mode. The directed tests therefore write in alternate mode and then switch the pin to output. An error in synchronizer depth shows as a read that arrives one cycle early or late, so the bench samples after the first edge and again after the second.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ALT   = 2'b00,
    MODE_OUT   = 2'b01,
    MODE_IN_PU = 2'b10,
    MODE_IN    = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int PINS = 8,
  localparam int CW  = gpio_mux_pkg::MODE_W * PINS
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            wr_en,
  input  logic            addr_sel,
  input  logic [CW-1:0]   wr_data,
  output logic [PINS-1:0] data_q,
  output logic [CW-1:0]   ctrl_q
);
  // Only power-on reset reaches these flops; warm reset leaves them alone.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (addr_sel) ctrl_q <= wr_data;
      else          data_q <= wr_data[PINS-1:0];
    end
  end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_mux_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              data_bit,
  input  logic              sync_bit,
  output logic              rd_bit,
  output logic              oe,
  output logic              pu,
  output logic              out
);
  pin_mode_e m;

  always_comb begin
    m      = pin_mode_e'(mode);
    oe     = (m == MODE_OUT);
    pu     = (m == MODE_IN_PU);
    out    = oe & data_bit;
    rd_bit = (m == MODE_IN_PU || m == MODE_IN) ? sync_bit : data_bit;
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   warm_rst_n,
  input  logic                   wr_en,
  input  logic                   addr_sel,
  input  logic [MODE_W*PINS-1:0] wr_data,
  output logic [MODE_W*PINS-1:0] rd_data,
  input  logic [PINS-1:0]        pin_in,
  output logic [PINS-1:0]        pin_out,
  output logic [PINS-1:0]        pin_oe,
  output logic [PINS-1:0]        pin_pu
);
  localparam int CW = MODE_W * PINS;

  logic [PINS-1:0] data_q;
  logic [CW-1:0]   ctrl_q;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] rd_mux;
  logic            sync_rst_n;

  assign sync_rst_n = por_n & warm_rst_n;

  gpio_regs #(.PINS(PINS)) regs_i (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr_sel(addr_sel),
    .wr_data(wr_data), .data_q(data_q), .ctrl_q(ctrl_q)
  );

  gpio_sync #(.W(PINS)) sync_i (
    .clk(clk), .rst_n(sync_rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    gpio_pin_slice slice_i (
      .mode    (ctrl_q[MODE_W*n +: MODE_W]),
      .data_bit(data_q[n]),
      .sync_bit(pin_sync[n]),
      .rd_bit  (rd_mux[n]),
      .oe      (pin_oe[n]),
      .pu      (pin_pu[n]),
      .out     (pin_out[n])
    );
  end

  always_comb begin
    if (addr_sel) rd_data = ctrl_q;
    else          rd_data = {{(CW-PINS){1'b0}}, rd_mux};
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int PINS = 8,
  localparam int CW  = 2 * PINS
) (
  input logic            clk,
  input logic            por_n,
  input logic            wr_en,
  input logic            addr_sel,
  input logic [CW-1:0]   wr_data,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pin_pu
);
  function automatic logic [PINS-1:0] f_code(input logic [CW-1:0] c, input logic [1:0] code);
    logic [PINS-1:0] r;
    for (int n = 0; n < PINS; n++) r[n] = (c[2*n +: 2] == code);
    return r;
  endfunction

  // R1: the enables are low while power-on reset is held.
  always @(posedge clk)
    if (!por_n) p_por_clear_r1: assert (pin_oe == '0 && pin_pu == '0 && pin_out == '0);

  p_oe_decode_r5: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr_sel) |=> (pin_oe == f_code($past(wr_data), 2'b01)));

  p_pu_decode_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr_sel) |=> (pin_pu == f_code($past(wr_data), 2'b10)));

  p_oe_pu_excl_r5: assert property (@(posedge clk) disable iff (!por_n)
    (pin_oe & pin_pu) == '0);

  p_out_gated_r7: assert property (@(posedge clk) disable iff (!por_n)
    (pin_out & ~pin_oe) == '0);

  p_data_write_r2: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !addr_sel) |=> (pin_out == ($past(wr_data[PINS-1:0]) & pin_oe)));

  // R8: with no write, warm reset or not, the pad controls hold.
  p_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> ($stable(pin_oe) && $stable(pin_pu) && $stable(pin_out)));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.PINS(PINS)) chk_i (.*);

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb_top;
  logic        clk = 0;
  logic        por_n = 0, warm_rst_n = 1, wr_en = 0, addr_sel = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [7:0]  pin_in = '0, pin_out, pin_oe, pin_pu;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_mux_port dut_i (.*);

  // {ctrl, data, pin, exp_rd, exp_oe, exp_pu, exp_out}
  localparam logic [63:0] VEC [6] = '{
    {16'h5555, 8'hA5, 8'h3C, 8'hA5, 8'hFF, 8'h00, 8'hA5}, // R2 R5 output
    {16'h0000, 8'h5A, 8'hFF, 8'h5A, 8'h00, 8'h00, 8'h00}, // R3 alternate
    {16'hAAAA, 8'hFF, 8'h3C, 8'h3C, 8'h00, 8'hFF, 8'h00}, // R4 R6 input pull-up
    {16'hFFFF, 8'h00, 8'hC3, 8'hC3, 8'h00, 8'h00, 8'h00}, // R4 input
    {16'hE4E4, 8'h96, 8'h55, 8'h56, 8'h22, 8'h44, 8'h02}, // R10 mixed
    {16'h1B1B, 8'h69, 8'hF0, 8'h78, 8'h44, 8'h22, 8'h40}  // R10 mixed
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr_sel = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    @(negedge clk); addr_sel = a; #1 v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    idle(2);
    // R1 reset state
    rd(0, v); chk("R1 data", v, 16'h0);
    rd(1, v); chk("R1 ctrl", v, 16'h0);
    chk("R1 enables", {pin_oe, pin_pu}, 16'h0);
    chk("R1 out", {8'h0, pin_out}, 16'h0);
    @(negedge clk); por_n = 1;
    idle(1);
    rd(0, v); chk("R1 after release", v, 16'h0);

    for (int i = 0; i < 6; i++) begin
      wr(1, VEC[i][63:48]);
      wr(0, {8'h0, VEC[i][47:40]});
      pin_in = VEC[i][39:32];
      idle(3);
      rd(0, v); chk($sformatf("R2 R3 R4 R10 rd vec%0d", i), v, {8'h0, VEC[i][31:24]});
      chk($sformatf("R5 oe vec%0d", i), {8'h0, pin_oe}, {8'h0, VEC[i][23:16]});
      chk($sformatf("R6 pu vec%0d", i), {8'h0, pin_pu}, {8'h0, VEC[i][15:8]});
      chk($sformatf("R5 out vec%0d", i), {8'h0, pin_out}, {8'h0, VEC[i][7:0]});
      rd(1, v); chk($sformatf("R9 ctrl vec%0d", i), v, VEC[i][63:48]);
    end

    // R7: a write in alternate mode is stored but not driven
    wr(1, 16'h0000);
    wr(0, 16'h00C3);
    chk("R7 out hidden", {8'h0, pin_out}, 16'h0);
    wr(1, 16'h5555);
    chk("R7 out after switch", {8'h0, pin_out}, 16'h00C3);
    rd(0, v); chk("R7 stored", v, 16'h00C3);

    // R4: two-flop latency
    wr(1, 16'hFFFF);
    pin_in = 8'h00; idle(3);
    pin_in = 8'hFF;
    @(posedge clk); rd(0, v); chk("R4 after one edge", v, 16'h0000);
    @(posedge clk); #1 v = rd_data; chk("R4 after two edges", v, 16'h00FF);

    // R9: field positions
    wr(1, 16'h0004); chk("R9 pin1 output", {8'h0, pin_oe}, 16'h0002);
    wr(1, 16'h8000); chk("R9 pin7 pull-up", {8'h0, pin_pu}, 16'h0080);

    // R8: warm reset keeps both registers
    wr(1, 16'h5555); wr(0, 16'h003A);
    @(negedge clk); warm_rst_n = 0; idle(2); warm_rst_n = 1; idle(1);
    rd(1, v); chk("R8 ctrl kept", v, 16'h5555);
    rd(0, v); chk("R8 data kept", v, 16'h003A);
    chk("R8 out kept", {8'h0, pin_out}, 16'h003A);

    // R1: power-on reset clears after use
    @(negedge clk); por_n = 0; idle(1);
    rd(0, v); chk("R1 por data", v, 16'h0);
    rd(1, v); chk("R1 por ctrl", v, 16'h0);
    @(negedge clk); por_n = 1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); tests++; fails++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule